// File: doc/BRIEF.md
# Memory Dependence Tracker

This block sits beside the issue queue of an out-of-order core and decides when each in-flight load or store may be sent to memory. When an instruction is dispatched, it is entered with its sequence number, PC, thread, kind and a flag saying whether its source registers are ready. The block then picks at most one producer for it. An active barrier is used first. Otherwise an external dependence predictor is asked, by PC, for the sequence number of a store the instruction should wait for. If the producer is still held in the 16-entry table, the instruction waits on it. Otherwise it is memory-ready at once.

When an instruction completes, every instruction waiting on it becomes memory-ready in the same cycle. Those whose registers are also ready are offered on the ready output, oldest first. A squash removes every entry and barrier younger than a given sequence number. Barriers are entered through the insert port as well: a full barrier blocks later loads and stores, and a write barrier blocks only stores. Sequence numbers are nonzero and increase without wrapping. Zero means "no producer".

Control is a three-state machine. `ST_IDLE` accepts an insert. An accepted insert goes to `ST_WRITE` when its producer is already known: it is non-speculative, it is a barrier, or a matching barrier is active. Otherwise it goes to `ST_LOOKUP`. `ST_LOOKUP` holds the predictor request until a response arrives and then goes to `ST_WRITE`. A squash covering the held instruction sends it back to `ST_IDLE`. `ST_WRITE` resolves the producer against the table, writes the entry and returns to `ST_IDLE`.

Top module: `memdep_tracker`

## Requirements
- R1: After reset, `ins_ready` is 1, `rq_valid` and `err_flag` are 0, and all four counters are 0.
- R2: Kind encoding is 01 load, 10 store, 11 barrier and 00 invalid. For a barrier, `ins_full_bar`=1 means a full barrier and 0 means a write barrier. While a full barrier is active, a load or store waits on the barrier and no predictor request is made.
- R3: A write barrier blocks stores only. A load inserted while only a write barrier is active queries the predictor.
- R4: With no matching barrier, the predictor is queried with the instruction's PC. A response of 0, or a sequence number not held in the table, makes the entry memory-ready. A response naming a held entry makes it wait on that entry.
- R5: An entry appears on the ready output only when it is both memory-ready and register-ready. Each such entry appears once.
- R6: Completion of an instruction (`done_valid`/`done_seq`) removes it and makes all of its waiting dependents memory-ready in one cycle. Those that are register-ready are offered in ascending sequence order.
- R7: A barrier flag clears on completion only when the completing sequence number equals the barrier's own.
- R8: A squash removes every entry and barrier flag whose sequence number is greater than `sq_seq`. Removed entries never appear on the ready output, and older entries keep their state.
- R9: Every inserted store, whether speculative or not, is reported once on `pred_st_*` with its PC, sequence number and thread.
- R10: A non-speculative insert skips the barrier and predictor checks and is memory-ready at once.
- R11: An insert of kind 00 raises `err_flag` in the next cycle and creates no entry. No counter changes.
- R12: Four counters record inserted loads, inserted stores, loads that waited on a producer and stores that waited on a producer.
- R13: `ins_ready` is low while an accepted insert is being processed and while all table entries are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_nonspec | input | 1 | Non-speculative insert |
| ins_kind | input | 2 | 01 load, 10 store, 11 barrier, 00 invalid |
| ins_full_bar | input | 1 | Barrier type: 1 full, 0 write |
| ins_seq | input | SEQ_W | Sequence number (nonzero) |
| ins_pc | input | PC_W | Instruction PC |
| ins_tid | input | TID_W | Thread |
| ins_regs_rdy | input | 1 | Source registers ready |
| ins_ready | output | 1 | Insert accepted this cycle when high |
| pred_req_valid | output | 1 | Predictor lookup request |
| pred_req_pc | output | PC_W | Lookup PC |
| pred_rsp_valid | input | 1 | Predictor response |
| pred_rsp_seq | input | SEQ_W | Producing store sequence, 0 for none |
| pred_st_valid | output | 1 | Store report to the predictor |
| pred_st_pc | output | PC_W | Reported store PC |
| pred_st_seq | output | SEQ_W | Reported store sequence |
| pred_st_tid | output | TID_W | Reported store thread |
| done_valid | input | 1 | Instruction completion |
| done_seq | input | SEQ_W | Completing sequence number |
| sq_valid | input | 1 | Squash |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| rq_valid | output | 1 | A ready entry is offered |
| rq_seq | output | SEQ_W | Sequence number of the oldest ready entry |
| rq_tid | output | TID_W | Its thread |
| rq_pop | input | 1 | Consume the offered entry |
| err_flag | output | 1 | Invalid-kind insert seen last cycle |
| cnt_ld_ins | output | CNT_W | Inserted loads |
| cnt_st_ins | output | CNT_W | Inserted stores |
| cnt_ld_conf | output | CNT_W | Loads that waited on a producer |
| cnt_st_conf | output | CNT_W | Stores that waited on a producer |

## Verification
A wrong producer choice shows at the ports in one of two ways. An instruction that should wait appears on the ready output two cycles after insert, or one that should be ready never appears. A wrongly entered lookup state shows as an unexpected or missing predictor request in the cycle after acceptance. A stale barrier flag or a missed wake-up shows only when the next affected instruction is inserted or its producer completes. The scoreboard reports it then as an ordering or missing-entry error on the ready output. A corrupted entry that a squash should have removed can surface at any later point as an extra ready sequence number.

// File: rtl/memdep_pkg.sv
`timescale 1ns/1ps
package memdep_pkg;
    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_BAR   = 2'b11
    } mem_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WRITE  = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/memdep_table.sv
`timescale 1ns/1ps
module memdep_table #(
    parameter int DEPTH = 16,
    parameter int SEQ_W = 16,
    parameter int TID_W = 2,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SEQ_W-1:0]                wr_seq,
    input  logic [TID_W-1:0]                wr_tid,
    input  logic                            wr_mem_rdy,
    input  logic                            wr_regs_rdy,
    input  logic                            wr_pend,
    input  logic [IDX_W-1:0]                wr_prod,
    input  logic [SEQ_W-1:0]                lk_seq,
    output logic                            lk_hit,
    output logic [IDX_W-1:0]                lk_idx,
    input  logic                            done_valid,
    input  logic [SEQ_W-1:0]                done_seq,
    input  logic                            sq_valid,
    input  logic [SEQ_W-1:0]                sq_seq,
    input  logic                            pop_en,
    input  logic [IDX_W-1:0]                pop_idx,
    output logic                            full,
    output logic [DEPTH-1:0]                pend_vec,
    output logic [DEPTH-1:0][SEQ_W-1:0]     seq_vec,
    output logic [DEPTH-1:0][TID_W-1:0]     tid_vec
);
    logic             valid_q [DEPTH];
    logic             memr_q  [DEPTH];
    logic             regr_q  [DEPTH];
    logic             pend_q  [DEPTH];
    logic [SEQ_W-1:0] seq_q   [DEPTH];
    logic [TID_W-1:0] tid_q   [DEPTH];
    logic [IDX_W-1:0] prod_q  [DEPTH];

    logic [DEPTH-1:0] done_hit;
    logic [DEPTH-1:0] kill;
    logic [DEPTH-1:0] lk_vec;
    logic [DEPTH-1:0] valid_vec;
    logic [IDX_W-1:0] free_idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic wake;
        assign done_hit[i]  = valid_q[i] && done_valid && (seq_q[i] == done_seq);
        assign kill[i]      = done_hit[i] || (valid_q[i] && sq_valid && (seq_q[i] > sq_seq));
        assign lk_vec[i]    = valid_q[i] && !kill[i] && (seq_q[i] == lk_seq);
        assign valid_vec[i] = valid_q[i];
        assign pend_vec[i]  = pend_q[i];
        assign seq_vec[i]   = seq_q[i];
        assign tid_vec[i]   = tid_q[i];
        assign wake         = valid_q[i] && !memr_q[i] && done_hit[prod_q[i]];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                memr_q[i]  <= 1'b0;
                regr_q[i]  <= 1'b0;
                pend_q[i]  <= 1'b0;
                seq_q[i]   <= '0;
                tid_q[i]   <= '0;
                prod_q[i]  <= '0;
            end else if (wr_en && (free_idx == IDX_W'(i))) begin
                valid_q[i] <= 1'b1;
                memr_q[i]  <= wr_mem_rdy;
                regr_q[i]  <= wr_regs_rdy;
                pend_q[i]  <= wr_pend;
                seq_q[i]   <= wr_seq;
                tid_q[i]   <= wr_tid;
                prod_q[i]  <= wr_prod;
            end else if (kill[i]) begin
                valid_q[i] <= 1'b0;
                pend_q[i]  <= 1'b0;
            end else begin
                if (wake) begin
                    memr_q[i] <= 1'b1;
                    if (regr_q[i]) pend_q[i] <= 1'b1;
                end
                if (pop_en && (pop_idx == IDX_W'(i))) pend_q[i] <= 1'b0;
            end
        end
    end

    assign full   = &valid_vec;
    assign lk_hit = |lk_vec;

    always_comb begin
        free_idx = '0;
        lk_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
            if (lk_vec[i])     lk_idx   = IDX_W'(i);
        end
    end
endmodule

// File: rtl/memdep_oldest.sv
`timescale 1ns/1ps
module memdep_oldest #(
    parameter int DEPTH = 16,
    parameter int SEQ_W = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            pend_vec,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq_vec,
    output logic                        any,
    output logic [IDX_W-1:0]            idx
);
    logic [SEQ_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (pend_vec[i] && (!any || (seq_vec[i] < best))) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = seq_vec[i];
            end
        end
    end
endmodule

// File: rtl/memdep_ctrl.sv
`timescale 1ns/1ps
module memdep_ctrl
    import memdep_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int TID_W = 2,
    parameter int IDX_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic             ins_nonspec,
    input  logic [1:0]       ins_kind,
    input  logic             ins_full_bar,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [TID_W-1:0] ins_tid,
    input  logic             ins_regs_rdy,
    output logic             ins_ready,
    output logic             pred_req_valid,
    output logic [PC_W-1:0]  pred_req_pc,
    input  logic             pred_rsp_valid,
    input  logic [SEQ_W-1:0] pred_rsp_seq,
    output logic             pred_st_valid,
    output logic [PC_W-1:0]  pred_st_pc,
    output logic [SEQ_W-1:0] pred_st_seq,
    output logic [TID_W-1:0] pred_st_tid,
    input  logic             done_valid,
    input  logic [SEQ_W-1:0] done_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             tbl_full,
    input  logic             lk_hit,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [SEQ_W-1:0] lk_seq,
    output logic             wr_en,
    output logic [SEQ_W-1:0] wr_seq,
    output logic [TID_W-1:0] wr_tid,
    output logic             wr_mem_rdy,
    output logic             wr_regs_rdy,
    output logic             wr_pend,
    output logic [IDX_W-1:0] wr_prod,
    output logic             err_flag,
    output logic [CNT_W-1:0] cnt_ld_ins,
    output logic [CNT_W-1:0] cnt_st_ins,
    output logic [CNT_W-1:0] cnt_ld_conf,
    output logic [CNT_W-1:0] cnt_st_conf
);
    ctrl_state_e      state_q, state_d;
    mem_kind_e        in_kind, h_kind;
    logic [SEQ_W-1:0] h_seq, h_prod;
    logic [PC_W-1:0]  h_pc;
    logic [TID_W-1:0] h_tid;
    logic             h_regs, h_full;
    logic             ld_bar_q, st_bar_q;
    logic [SEQ_W-1:0] ld_bar_seq, st_bar_seq;
    logic             err_q;

    logic             accept, take, direct, ld_block, st_block, abort, found;
    logic [SEQ_W-1:0] direct_prod;

    assign in_kind  = mem_kind_e'(ins_kind);
    assign accept   = (state_q == ST_IDLE) && ins_valid && !tbl_full;
    assign take     = accept && (in_kind != KIND_NONE);
    assign ld_block = (in_kind == KIND_LOAD)  && ld_bar_q;
    assign st_block = (in_kind == KIND_STORE) && st_bar_q;
    assign direct   = ins_nonspec || (in_kind == KIND_BAR) || ld_block || st_block;
    assign abort    = sq_valid && (h_seq > sq_seq);

    always_comb begin
        if (ins_nonspec || (in_kind == KIND_BAR)) direct_prod = '0;
        else if (ld_block)                        direct_prod = ld_bar_seq;
        else if (st_block)                        direct_prod = st_bar_seq;
        else                                      direct_prod = '0;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take) state_d = direct ? ST_WRITE : ST_LOOKUP;
            ST_LOOKUP: begin
                if (abort)               state_d = ST_IDLE;
                else if (pred_rsp_valid) state_d = ST_WRITE;
            end
            ST_WRITE:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        found          = (h_prod != '0) && lk_hit;
        ins_ready      = (state_q == ST_IDLE) && !tbl_full;
        pred_req_valid = (state_q == ST_LOOKUP);
        pred_req_pc    = h_pc;
        lk_seq         = h_prod;
        wr_en          = (state_q == ST_WRITE) && !abort;
        wr_seq         = h_seq;
        wr_tid         = h_tid;
        wr_mem_rdy     = !found;
        wr_regs_rdy    = h_regs && (h_kind != KIND_BAR);
        wr_pend        = !found && wr_regs_rdy;
        wr_prod        = lk_idx;
        pred_st_valid  = wr_en && (h_kind == KIND_STORE);
        pred_st_pc     = h_pc;
        pred_st_seq    = h_seq;
        pred_st_tid    = h_tid;
        err_flag       = err_q;
    end

    // Held instruction and producer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_kind <= KIND_NONE;
            h_seq  <= '0;
            h_prod <= '0;
            h_pc   <= '0;
            h_tid  <= '0;
            h_regs <= 1'b0;
            h_full <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= accept && (in_kind == KIND_NONE);
            if (take) begin
                h_kind <= in_kind;
                h_seq  <= ins_seq;
                h_prod <= direct_prod;
                h_pc   <= ins_pc;
                h_tid  <= ins_tid;
                h_regs <= ins_regs_rdy;
                h_full <= ins_full_bar;
            end else if ((state_q == ST_LOOKUP) && pred_rsp_valid) begin
                h_prod <= pred_rsp_seq;
            end
        end
    end

    // Barrier flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_bar_q   <= 1'b0;
            st_bar_q   <= 1'b0;
            ld_bar_seq <= '0;
            st_bar_seq <= '0;
        end else begin
            if (sq_valid && (ld_bar_seq > sq_seq))          ld_bar_q <= 1'b0;
            else if (done_valid && (done_seq == ld_bar_seq)) ld_bar_q <= 1'b0;
            if (sq_valid && (st_bar_seq > sq_seq))          st_bar_q <= 1'b0;
            else if (done_valid && (done_seq == st_bar_seq)) st_bar_q <= 1'b0;
            if (wr_en && (h_kind == KIND_BAR)) begin
                st_bar_q   <= 1'b1;
                st_bar_seq <= h_seq;
                if (h_full) begin
                    ld_bar_q   <= 1'b1;
                    ld_bar_seq <= h_seq;
                end
            end
        end
    end

    // Event counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_ld_ins  <= '0;
            cnt_st_ins  <= '0;
            cnt_ld_conf <= '0;
            cnt_st_conf <= '0;
        end else if (wr_en) begin
            if (h_kind == KIND_LOAD) begin
                cnt_ld_ins <= cnt_ld_ins + 1'b1;
                if (found) cnt_ld_conf <= cnt_ld_conf + 1'b1;
            end
            if (h_kind == KIND_STORE) begin
                cnt_st_ins <= cnt_st_ins + 1'b1;
                if (found) cnt_st_conf <= cnt_st_conf + 1'b1;
            end
        end
    end
endmodule

// File: rtl/memdep_tracker.sv
`timescale 1ns/1ps
module memdep_tracker #(
    parameter int DEPTH = 16,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int TID_W = 2,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic             ins_nonspec,
    input  logic [1:0]       ins_kind,
    input  logic             ins_full_bar,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [TID_W-1:0] ins_tid,
    input  logic             ins_regs_rdy,
    output logic             ins_ready,
    output logic             pred_req_valid,
    output logic [PC_W-1:0]  pred_req_pc,
    input  logic             pred_rsp_valid,
    input  logic [SEQ_W-1:0] pred_rsp_seq,
    output logic             pred_st_valid,
    output logic [PC_W-1:0]  pred_st_pc,
    output logic [SEQ_W-1:0] pred_st_seq,
    output logic [TID_W-1:0] pred_st_tid,
    input  logic             done_valid,
    input  logic [SEQ_W-1:0] done_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             rq_valid,
    output logic [SEQ_W-1:0] rq_seq,
    output logic [TID_W-1:0] rq_tid,
    input  logic             rq_pop,
    output logic             err_flag,
    output logic [CNT_W-1:0] cnt_ld_ins,
    output logic [CNT_W-1:0] cnt_st_ins,
    output logic [CNT_W-1:0] cnt_ld_conf,
    output logic [CNT_W-1:0] cnt_st_conf
);
    localparam int IDX_W = $clog2(DEPTH);

    logic                        tbl_full, lk_hit, wr_en, wr_mem_rdy, wr_regs_rdy, wr_pend;
    logic [IDX_W-1:0]            lk_idx, wr_prod, pick_idx;
    logic [SEQ_W-1:0]            lk_seq, wr_seq;
    logic [TID_W-1:0]            wr_tid;
    logic [DEPTH-1:0]            pend_vec;
    logic [DEPTH-1:0][SEQ_W-1:0] seq_vec;
    logic [DEPTH-1:0][TID_W-1:0] tid_vec;
    logic                        pick_any;

    memdep_ctrl #(.SEQ_W(SEQ_W), .PC_W(PC_W), .TID_W(TID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk, .rst_n, .ins_valid, .ins_nonspec, .ins_kind, .ins_full_bar, .ins_seq, .ins_pc,
        .ins_tid, .ins_regs_rdy, .ins_ready, .pred_req_valid, .pred_req_pc, .pred_rsp_valid,
        .pred_rsp_seq, .pred_st_valid, .pred_st_pc, .pred_st_seq, .pred_st_tid, .done_valid,
        .done_seq, .sq_valid, .sq_seq, .tbl_full, .lk_hit, .lk_idx, .lk_seq, .wr_en, .wr_seq,
        .wr_tid, .wr_mem_rdy, .wr_regs_rdy, .wr_pend, .wr_prod, .err_flag, .cnt_ld_ins,
        .cnt_st_ins, .cnt_ld_conf, .cnt_st_conf
    );

    memdep_table #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .TID_W(TID_W), .IDX_W(IDX_W)) u_table (
        .clk, .rst_n, .wr_en, .wr_seq, .wr_tid, .wr_mem_rdy, .wr_regs_rdy, .wr_pend, .wr_prod,
        .lk_seq, .lk_hit, .lk_idx, .done_valid, .done_seq, .sq_valid, .sq_seq,
        .pop_en(rq_pop && pick_any), .pop_idx(pick_idx), .full(tbl_full),
        .pend_vec, .seq_vec, .tid_vec
    );

    memdep_oldest #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
        .pend_vec, .seq_vec, .any(pick_any), .idx(pick_idx)
    );

    assign rq_valid = pick_any;
    assign rq_seq   = seq_vec[pick_idx];
    assign rq_tid   = tid_vec[pick_idx];
endmodule

// File: rtl/memdep_chk.sv
`timescale 1ns/1ps
module memdep_chk #(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             ins_ready,
    input logic             ins_nonspec,
    input logic [1:0]       ins_kind,
    input logic [SEQ_W-1:0] ins_seq,
    input logic             err_flag,
    input logic             pred_req_valid,
    input logic [PC_W-1:0]  pred_req_pc,
    input logic             pred_rsp_valid,
    input logic             pred_st_valid,
    input logic [SEQ_W-1:0] pred_st_seq,
    input logic             sq_valid,
    input logic             done_valid,
    input logic             rq_valid,
    input logic             rq_pop,
    input logic [CNT_W-1:0] cnt_ld_ins
);
    AST_BAD_KIND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && ins_kind == 2'b00) |=> err_flag); // R11

    AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> $past(ins_valid && ins_ready && ins_kind == 2'b00)); // R11

    AST_STORE_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && ins_nonspec && ins_kind == 2'b10)
        |=> (sq_valid || (pred_st_valid && pred_st_seq == $past(ins_seq)))); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_req_valid && !pred_rsp_valid && !sq_valid)
        |=> (pred_req_valid && $stable(pred_req_pc))); // R4

    AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && !rq_pop && !done_valid && !sq_valid) |=> rq_valid); // R5

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && ins_kind != 2'b00) |=> !ins_ready); // R13

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ld_ins - $past(cnt_ld_ins)) <= CNT_W'(1)); // R12
endmodule

bind memdep_tracker memdep_chk #(.SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_memdep_tracker.sv
`timescale 1ns/1ps
module tb_memdep_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0, ins_nonspec = 1'b0, ins_full_bar = 1'b0, ins_regs_rdy = 1'b0;
    logic [1:0]  ins_kind = 2'b00;
    logic [15:0] ins_seq = '0;
    logic [31:0] ins_pc = '0;
    logic [1:0]  ins_tid = '0;
    logic        ins_ready, pred_req_valid, pred_rsp_valid, pred_st_valid;
    logic [31:0] pred_req_pc, pred_st_pc;
    logic [15:0] pred_rsp_seq, pred_st_seq;
    logic [1:0]  pred_st_tid, rq_tid;
    logic        done_valid = 1'b0, sq_valid = 1'b0, rq_pop = 1'b1;
    logic [15:0] done_seq = '0, sq_seq = '0, rq_seq, pred_ans = '0;
    logic        rq_valid, err_flag;
    logic [15:0] cnt_ld_ins, cnt_st_ins, cnt_ld_conf, cnt_st_conf;

    int n_checks = 0, n_fail = 0, lookups = 0;
    int e_ld = 0, e_st = 0, e_cld = 0, e_cst = 0;
    bit finished = 1'b0;
    logic [15:0] exp_q[$];
    logic [49:0] st_q[$];

    always #2.5 clk = ~clk;

    assign pred_rsp_valid = pred_req_valid;
    assign pred_rsp_seq   = pred_ans;

    memdep_tracker dut (
        .clk, .rst_n, .ins_valid, .ins_nonspec, .ins_kind, .ins_full_bar, .ins_seq, .ins_pc,
        .ins_tid, .ins_regs_rdy, .ins_ready, .pred_req_valid, .pred_req_pc, .pred_rsp_valid,
        .pred_rsp_seq, .pred_st_valid, .pred_st_pc, .pred_st_seq, .pred_st_tid, .done_valid,
        .done_seq, .sq_valid, .sq_seq, .rq_valid, .rq_seq, .rq_tid, .rq_pop, .err_flag,
        .cnt_ld_ins, .cnt_st_ins, .cnt_ld_conf, .cnt_st_conf
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) if (rst_n && pred_req_valid) lookups++;

    // Monitor: ready output and store reports against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rq_valid) begin
                if (exp_q.size() == 0) chk(1'b0, "R5/R8 unexpected ready entry", rq_seq, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rq_seq == e, "R5/R6 ready order", rq_seq, e);
                end
            end
            if (pred_st_valid) begin
                if (st_q.size() == 0) chk(1'b0, "R9 unexpected store report", pred_st_seq, 0);
                else begin
                    logic [49:0] s;
                    s = st_q.pop_front();
                    chk({pred_st_pc, pred_st_seq, pred_st_tid} == s, "R9 store report",
                        {pred_st_pc, pred_st_seq, pred_st_tid}, s);
                end
            end
        end
    end

    task automatic ins(input logic [1:0] k, input bit fb, input bit ns, input logic [15:0] s,
                       input bit rr, input bit exp_rdy, input bit exp_park, input int exp_lk,
                       input bit wait_done, input string tag);
        int lk0;
        lk0 = lookups;
        if (exp_rdy) exp_q.push_back(s);
        if (k == 2'b10) st_q.push_back({32'h1000 + 32'(s) * 4, s, s[1:0]});
        if (k == 2'b01) begin e_ld++; if (exp_park) e_cld++; end
        if (k == 2'b10) begin e_st++; if (exp_park) e_cst++; end
        ins_valid = 1'b1; ins_kind = k; ins_full_bar = fb; ins_nonspec = ns; ins_seq = s;
        ins_pc = 32'h1000 + 32'(s) * 4; ins_tid = s[1:0]; ins_regs_rdy = rr;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        if (wait_done) while (!ins_ready) @(negedge clk);
        chk(lookups - lk0 == exp_lk, tag, lookups - lk0, exp_lk);
    endtask

    task automatic finish_seq(input logic [15:0] s);
        done_valid = 1'b1; done_seq = s;
        @(posedge clk);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic squash(input logic [15:0] s);
        sq_valid = 1'b1; sq_seq = s;
        @(posedge clk);
        @(negedge clk);
        sq_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ins_ready == 1'b1, "R1 ins_ready", ins_ready, 1);
        chk(rq_valid == 1'b0, "R1 rq_valid", rq_valid, 0);
        chk(err_flag == 1'b0, "R1 err_flag", err_flag, 0);
        chk({cnt_ld_ins, cnt_st_ins, cnt_ld_conf, cnt_st_conf} == '0, "R1 counters",
            {cnt_ld_ins, cnt_st_ins, cnt_ld_conf, cnt_st_conf}, 0);

        // R4 predictor lookups
        pred_ans = 16'd0;
        ins(2'b01, 0, 0, 16'd1, 1, 1, 0, 1, 1, "R4 load no producer");
        ins(2'b10, 0, 0, 16'd2, 1, 1, 0, 1, 1, "R4 store no producer");
        pred_ans = 16'd2;
        ins(2'b01, 0, 0, 16'd3, 1, 0, 1, 1, 1, "R4 load parks on store");
        ins(2'b01, 0, 0, 16'd4, 0, 0, 1, 1, 1, "R5 parked load regs not ready");
        ins(2'b01, 0, 0, 16'd5, 1, 0, 1, 1, 1, "R4 second load parks");
        idle(2);
        // R6 wake-up of all dependents, oldest first; 4 stays out (R5)
        exp_q.push_back(16'd3); exp_q.push_back(16'd5);
        finish_seq(16'd2);
        idle(3);
        chk(exp_q.size() == 0, "R6 woken dependents delivered", exp_q.size(), 0);
        pred_ans = 16'd99;
        ins(2'b10, 0, 0, 16'd6, 1, 1, 0, 1, 1, "R4 producer not held");

        // R2 full barrier, R7 matching completion
        ins(2'b11, 1, 0, 16'd10, 1, 0, 0, 0, 1, "R2 full barrier insert");
        ins(2'b01, 0, 0, 16'd11, 1, 0, 1, 0, 1, "R2 load blocked by full barrier");
        ins(2'b10, 0, 0, 16'd12, 1, 0, 1, 0, 1, "R2 store blocked by full barrier");
        finish_seq(16'd9);
        ins(2'b01, 0, 0, 16'd13, 1, 0, 1, 0, 1, "R7 flag kept on other completion");
        idle(2);
        exp_q.push_back(16'd11); exp_q.push_back(16'd12); exp_q.push_back(16'd13);
        finish_seq(16'd10);
        idle(4);
        chk(exp_q.size() == 0, "R6 barrier dependents delivered", exp_q.size(), 0);
        pred_ans = 16'd0;
        ins(2'b01, 0, 0, 16'd14, 1, 1, 0, 1, 1, "R7 flag cleared on matching completion");

        // R3 write barrier, R10 non-speculative
        ins(2'b11, 0, 0, 16'd20, 1, 0, 0, 0, 1, "R3 write barrier insert");
        ins(2'b01, 0, 0, 16'd21, 1, 1, 0, 1, 1, "R3 load not blocked");
        ins(2'b10, 0, 0, 16'd22, 1, 0, 1, 0, 1, "R3 store blocked");
        ins(2'b01, 0, 1, 16'd23, 1, 1, 0, 0, 1, "R10 nonspec load skips checks");
        ins(2'b10, 0, 1, 16'd24, 1, 1, 0, 0, 1, "R10 nonspec store skips checks");
        idle(3);

        // R8 squash younger than 19: barrier and 22 go, store 6 stays
        squash(16'd19);
        idle(3);
        ins(2'b10, 0, 0, 16'd25, 1, 1, 0, 1, 1, "R8 squashed barrier gone");
        pred_ans = 16'd6;
        ins(2'b01, 0, 0, 16'd26, 1, 0, 1, 1, 1, "R8 older store kept");
        idle(2);
        exp_q.push_back(16'd26);
        finish_seq(16'd6);
        idle(3);

        // R11 invalid kind
        ins_valid = 1'b1; ins_kind = 2'b00; ins_seq = 16'd30; ins_nonspec = 1'b0;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        chk(err_flag == 1'b1, "R11 err_flag raised", err_flag, 1);
        chk(ins_ready == 1'b1, "R11 stays ready", ins_ready, 1);
        @(negedge clk);
        chk(err_flag == 1'b0, "R11 err_flag one cycle", err_flag, 0);

        // R12 counters
        chk(cnt_ld_ins == 16'(e_ld), "R12 loads inserted", cnt_ld_ins, e_ld);
        chk(cnt_st_ins == 16'(e_st), "R12 stores inserted", cnt_st_ins, e_st);
        chk(cnt_ld_conf == 16'(e_cld), "R12 conflicting loads", cnt_ld_conf, e_cld);
        chk(cnt_st_conf == 16'(e_cst), "R12 conflicting stores", cnt_st_conf, e_cst);

        // R13 table full
        squash(16'd0);
        idle(2);
        for (int i = 0; i < 15; i++)
            ins(2'b01, 0, 1, 16'(40 + i), 0, 0, 0, 0, 1, "R13 fill entry");
        ins(2'b01, 0, 1, 16'd55, 0, 0, 0, 0, 0, "R13 last fill entry");
        @(negedge clk);
        chk(ins_ready == 1'b0, "R13 full blocks insert", ins_ready, 0);
        squash(16'd0);
        chk(ins_ready == 1'b1, "R13 ready after squash", ins_ready, 1);
        chk(cnt_ld_ins == 16'(e_ld), "R12 loads after fill", cnt_ld_ins, e_ld);

        idle(4);
        chk(exp_q.size() == 0, "R5 all expected ready entries seen", exp_q.size(), 0);
        chk(st_q.size() == 0, "R9 all store reports seen", st_q.size(), 0);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule